// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block keeps the thread-mask history of one warp in a SIMT core that has explicit split and join instructions. At a split it receives the warp's active lane mask, one predicate bit per lane and the program counter of the split. It decides whether the active lanes agree on the predicate and records reconvergence state on a fixed-depth stack. At a join it pops the newest record, hands back the lane mask to resume with and, when the record belongs to the taken side of a divergent branch, asks the fetch unit to redirect to the stored program counter.

A split or join is one command per warp instruction, whatever the number of lanes. It is acted on even if the issuing lane is masked off. A unanimous branch costs one stack slot and leaves the mask alone. A divergent branch costs two slots: a record that restores the full mask, and above it a record for the taken lanes with the split PC. The lanes that do not take the branch run first. Illegal commands (no active lane, no room, nothing to pop) raise a one-cycle error and change no state.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, nextMask is all zeros, redirectValid and all three error flags are 0, and the stack is empty.
- R2: A split where every lane whose curMask bit is 1 carries the same predBits value is unanimous. Predicate bits of inactive lanes are ignored. It pushes one uniform record holding curMask, and in the next cycle nextMask equals curMask with no error.
- R3: A split with curMask all zeros pulses divergeErr for one cycle, pushes nothing and leaves nextMask at its previous value.
- R4: A divergent split pushes two records. The first is a fall-through record holding curMask. The second holds curMask & predBits and curPc. In the next cycle nextMask equals curMask & ~predBits.
- R5: A join whose top record is uniform pops it and sets nextMask to the stored mask. redirectValid stays 0.
- R6: A join whose top record is a taken-side record pops it and sets nextMask to its mask. redirectValid is 1 for exactly one cycle, with redirectPc equal to the stored PC.
- R7: A join whose top record is fall-through pops it and restores the saved mask on nextMask. redirectValid stays 0.
- R8: A split needing more free slots than remain pulses overflowErr, pushes nothing and keeps nextMask. A unanimous split needs one free slot and a divergent split needs two.
- R9: A join on an empty stack pulses underflowErr and keeps nextMask. redirectValid stays 0.
- R10: When splitValid and joinValid are both 1 in one cycle, only the split is acted on and the join is ignored.
- R11: A split with no active lane reports only divergeErr, even when the stack is full.
- R12: All outputs change at the clock edge that samples a command. In cycles without a command, nextMask holds and the pulse outputs are 0. Records come back last in, first out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| splitValid | input | 1 | Split command strobe, one cycle per warp instruction |
| joinValid | input | 1 | Join command strobe, one cycle per warp instruction |
| curMask | input | THREADS | Active lane mask at the command |
| predBits | input | THREADS | Per-lane predicate for a split |
| curPc | input | PC_W | Program counter of the split |
| nextMask | output | THREADS | Lane mask to resume with |
| redirectValid | output | 1 | One-cycle request to redirect fetch |
| redirectPc | output | PC_W | Redirect target, valid with redirectValid |
| divergeErr | output | 1 | Split issued with no active lane |
| overflowErr | output | 1 | Split found too few free slots |
| underflowErr | output | 1 | Join found the stack empty |

## Verification
Two things can meet in one cycle. The first is a split and a join issued together. The bench does this on an empty stack and checks that no underflow appears, that nextMask takes the split's result, and that a later join pops the record that split pushed. The second is a split with no active lane on a full stack. Here the lane check and the capacity check both fail, and the bench checks that only divergeErr rises. The main sweep covers every mask and predicate pair for a four-lane warp. Every split is followed by the joins it implies, and each mask and redirect is predicted with bitwise arithmetic.

// File: rtl/simt_reconv_pkg.sv
package simt_reconv_pkg;
  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic pushUni;
    logic pushDiv;
    logic pop;
    logic errDiverge;
    logic errOver;
    logic errUnder;
  } stackCtrl_t;
endpackage

// File: rtl/simt_reconv_ctrl.sv
module simt_reconv_ctrl
  import simt_reconv_pkg::*;
#(
  parameter int THREADS = 8,
  parameter int DEPTH   = 16,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               splitValid,
  input  logic               joinValid,
  input  logic [THREADS-1:0] curMask,
  input  logic [THREADS-1:0] predBits,
  input  logic [CNT_W-1:0]   used,
  output stackCtrl_t         ctrl,
  output logic [THREADS-1:0] takenMask
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] freeSlots;
  logic             anyActive;
  logic             uniform;

  always_comb begin
    takenMask = curMask & predBits;
    anyActive = |curMask;
    uniform   = (takenMask == '0) || (takenMask == curMask);
    freeSlots = DEPTH_C - used;
    ctrl      = '0;
    if (splitValid) begin
      if (!anyActive)               ctrl.errDiverge = 1'b1;
      else if (uniform) begin
        if (freeSlots >= CNT_W'(1)) ctrl.pushUni    = 1'b1;
        else                        ctrl.errOver    = 1'b1;
      end else begin
        if (freeSlots >= CNT_W'(2)) ctrl.pushDiv    = 1'b1;
        else                        ctrl.errOver    = 1'b1;
      end
    end else if (joinValid) begin
      if (used == '0)               ctrl.errUnder   = 1'b1;
      else                          ctrl.pop        = 1'b1;
    end
  end
endmodule

// File: rtl/simt_reconv_dp.sv
module simt_reconv_dp
  import simt_reconv_pkg::*;
#(
  parameter int THREADS = 8,
  parameter int DEPTH   = 16,
  parameter int PC_W    = 32,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  stackCtrl_t         ctrl,
  input  logic [THREADS-1:0] curMask,
  input  logic [THREADS-1:0] takenMask,
  input  logic [PC_W-1:0]    curPc,
  output logic [CNT_W-1:0]   used,
  output logic [THREADS-1:0] nextMask,
  output logic               redirectValid,
  output logic [PC_W-1:0]    redirectPc,
  output logic               divergeErr,
  output logic               overflowErr,
  output logic               underflowErr
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  typedef struct packed {
    logic [THREADS-1:0] mask;
    logic [PC_W-1:0]    pc;
    logic               uni;
    logic               fall;
  } entry_t;

  entry_t slots [DEPTH];
  entry_t topEntry;

  always_comb begin
    topEntry = '0;
    for (int i = 0; i < DEPTH; i++)
      if (CNT_W'(i + 1) == used) topEntry = slots[i];
  end

  // slot storage: each slot compares its own index with the fill level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ctrl.pushUni && CNT_W'(i) == used)
          slots[i] <= '{mask: curMask, pc: curPc, uni: 1'b1, fall: 1'b0};
        if (ctrl.pushDiv && CNT_W'(i) == used)
          slots[i] <= '{mask: curMask, pc: curPc, uni: 1'b0, fall: 1'b1};
        if (ctrl.pushDiv && CNT_W'(i) == used + CNT_W'(1))
          slots[i] <= '{mask: takenMask, pc: curPc, uni: 1'b0, fall: 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      used          <= '0;
      nextMask      <= '0;
      redirectValid <= 1'b0;
      redirectPc    <= '0;
      divergeErr    <= 1'b0;
      overflowErr   <= 1'b0;
      underflowErr  <= 1'b0;
    end else begin
      redirectValid <= 1'b0;
      divergeErr    <= ctrl.errDiverge;
      overflowErr   <= ctrl.errOver;
      underflowErr  <= ctrl.errUnder;
      if (ctrl.pushUni) begin
        used     <= used + CNT_W'(1);
        nextMask <= curMask;
      end else if (ctrl.pushDiv) begin
        used     <= used + CNT_W'(2);
        nextMask <= curMask & ~takenMask;
      end else if (ctrl.pop) begin
        used     <= used - CNT_W'(1);
        nextMask <= topEntry.mask;
        if (!topEntry.uni && !topEntry.fall) begin
          redirectValid <= 1'b1;
          redirectPc    <= topEntry.pc;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    used <= DEPTH_C); // R8
  AST_REDIRECT_FROM_POP: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> $past(ctrl.pop)); // R6
  AST_DIV_MASK_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.pushDiv) |-> ((nextMask & $past(takenMask)) == '0) && (nextMask != '0)); // R4
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({divergeErr, overflowErr, underflowErr, redirectValid})); // R11
  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |-> $stable(nextMask)); // R9
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_reconv_pkg::*;
#(
  parameter int THREADS = 8,
  parameter int DEPTH   = 16,
  parameter int PC_W    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               splitValid,
  input  logic               joinValid,
  input  logic [THREADS-1:0] curMask,
  input  logic [THREADS-1:0] predBits,
  input  logic [PC_W-1:0]    curPc,
  output logic [THREADS-1:0] nextMask,
  output logic               redirectValid,
  output logic [PC_W-1:0]    redirectPc,
  output logic               divergeErr,
  output logic               overflowErr,
  output logic               underflowErr
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  stackCtrl_t         ctrl;
  logic [THREADS-1:0] takenMask;
  logic [CNT_W-1:0]   used;

  simt_reconv_ctrl #(.THREADS(THREADS), .DEPTH(DEPTH), .CNT_W(CNT_W)) uCtrl (
    .splitValid(splitValid), .joinValid(joinValid), .curMask(curMask),
    .predBits(predBits), .used(used), .ctrl(ctrl), .takenMask(takenMask)
  );

  simt_reconv_dp #(.THREADS(THREADS), .DEPTH(DEPTH), .PC_W(PC_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .curMask(curMask), .takenMask(takenMask),
    .curPc(curPc), .used(used), .nextMask(nextMask), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .divergeErr(divergeErr), .overflowErr(overflowErr),
    .underflowErr(underflowErr)
  );
endmodule

// File: tb/tb_simt_reconv_stack.sv
module tb_simt_reconv_stack;
  localparam int TH = 4;
  localparam int DP = 4;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          splitValid = 1'b0, joinValid = 1'b0;
  logic [TH-1:0] curMask = '0, predBits = '0;
  logic [PW-1:0] curPc = '0;
  logic [TH-1:0] nextMask;
  logic          redirectValid, divergeErr, overflowErr, underflowErr;
  logic [PW-1:0] redirectPc;

  int checks = 0;
  int fails  = 0;
  logic [TH-1:0] expMask = '0;

  always #5 clk = ~clk;

  simt_reconv_stack #(.THREADS(TH), .DEPTH(DP), .PC_W(PW)) dut (
    .clk(clk), .rstN(rstN), .splitValid(splitValid), .joinValid(joinValid),
    .curMask(curMask), .predBits(predBits), .curPc(curPc), .nextMask(nextMask),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .divergeErr(divergeErr),
    .overflowErr(overflowErr), .underflowErr(underflowErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one command for one cycle; on return the registered results are visible
  task automatic cmd(input logic s, input logic j, input logic [TH-1:0] m,
                     input logic [TH-1:0] p, input logic [PW-1:0] pc);
    @(negedge clk);
    splitValid = s; joinValid = j; curMask = m; predBits = p; curPc = pc;
    @(negedge clk);
    splitValid = 1'b0; joinValid = 1'b0;
  endtask

  task automatic chkErr(input string tag, input logic d, input logic o, input logic u);
    chk({tag, " divergeErr"}, 32'(divergeErr), 32'(d));
    chk({tag, " overflowErr"}, 32'(overflowErr), 32'(o));
    chk({tag, " underflowErr"}, 32'(underflowErr), 32'(u));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 nextMask", 32'(nextMask), 0);
    chk("R1 redirectValid", 32'(redirectValid), 0);
    chkErr("R1", 0, 0, 0);

    // exhaustive sweep of mask and predicate pairs
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        logic [TH-1:0] mm, pp, tk;
        logic [PW-1:0] pc;
        mm = TH'(m); pp = TH'(p); tk = mm & pp;
        pc = PW'(m * 256 + p * 4 + 4096);
        cmd(1, 0, mm, pp, pc);
        if (mm == 0) begin
          chkErr("R3", 1, 0, 0);
          chk("R3 mask held", 32'(nextMask), 32'(expMask));
        end else if (tk == 0 || tk == mm) begin
          chk("R2 uniform mask", 32'(nextMask), 32'(mm));
          chkErr("R2", 0, 0, 0);
          cmd(0, 1, 0, 0, 0);
          chk("R5 uniform join mask", 32'(nextMask), 32'(mm));
          chk("R5 no redirect", 32'(redirectValid), 0);
          expMask = mm;
        end else begin
          chk("R4 else-side mask", 32'(nextMask), 32'(mm & ~pp));
          chkErr("R4", 0, 0, 0);
          cmd(0, 1, 0, 0, 0);
          chk("R6 redirect", 32'(redirectValid), 1);
          chk("R6 redirectPc", 32'(redirectPc), 32'(pc));
          chk("R6 taken mask", 32'(nextMask), 32'(tk));
          @(negedge clk);
          chk("R12 redirect pulse ends", 32'(redirectValid), 0);
          chk("R12 mask holds idle", 32'(nextMask), 32'(tk));
          cmd(0, 1, 0, 0, 0);
          chk("R7 fall-through mask", 32'(nextMask), 32'(mm));
          chk("R7 no redirect", 32'(redirectValid), 0);
          expMask = mm;
        end
      end
    end

    // empty join
    cmd(0, 1, 4'hF, 4'hF, 0);
    chkErr("R9", 0, 0, 1);
    chk("R9 mask held", 32'(nextMask), 32'(expMask));
    chk("R9 no redirect", 32'(redirectValid), 0);

    // fill with uniform splits
    for (int k = 0; k < DP; k++) begin
      cmd(1, 0, TH'(k + 1), 0, 0);
      chk("R8 fill accepted", 32'(overflowErr), 0);
    end
    cmd(1, 0, 4'h6, 4'h0, 0);
    chkErr("R8 full uniform", 0, 1, 0);
    chk("R8 mask held", 32'(nextMask), 32'(DP));
    cmd(1, 0, 4'h0, 4'h0, 0);
    chkErr("R11 empty on full", 1, 0, 0);
    cmd(0, 1, 0, 0, 0);
    chk("R12 LIFO pop", 32'(nextMask), 32'(DP));
    cmd(1, 0, 4'hF, 4'h3, 16'h0777);
    chkErr("R8 divergent one slot", 0, 1, 0);
    chk("R8 divergent mask held", 32'(nextMask), 32'(DP));
    for (int k = DP - 1; k >= 1; k--) begin
      cmd(0, 1, 0, 0, 0);
      chk("R12 LIFO drain", 32'(nextMask), 32'(k));
    end

    // nested divergence
    cmd(1, 0, 4'hF, 4'h3, 16'h0100);
    chk("R4 outer", 32'(nextMask), 32'hC);
    cmd(1, 0, 4'hC, 4'h4, 16'h0200);
    chk("R4 inner", 32'(nextMask), 32'h8);
    cmd(0, 1, 0, 0, 0);
    chk("R6 inner pc", 32'(redirectPc), 32'h0200);
    chk("R6 inner mask", 32'(nextMask), 32'h4);
    cmd(0, 1, 0, 0, 0);
    chk("R7 inner restore", 32'(nextMask), 32'hC);
    cmd(0, 1, 0, 0, 0);
    chk("R6 outer pc", 32'(redirectPc), 32'h0100);
    chk("R6 outer redirect", 32'(redirectValid), 1);
    chk("R6 outer mask", 32'(nextMask), 32'h3);
    cmd(0, 1, 0, 0, 0);
    chk("R7 outer restore", 32'(nextMask), 32'hF);

    // split and join together on an empty stack
    cmd(1, 1, 4'h5, 4'hD, 0);
    chkErr("R10 same cycle", 0, 0, 0);
    chk("R10 split acted", 32'(nextMask), 32'h5);
    cmd(0, 1, 0, 0, 0);
    chk("R10 entry present", 32'(underflowErr), 0);
    chk("R10 entry mask", 32'(nextMask), 32'h5);
    cmd(0, 1, 0, 0, 0);
    chk("R10 stack empty again", 32'(underflowErr), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule